// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a 32-bit base integer core and works out where execution goes next. Each cycle it looks at the current PC, the instruction word and the two source operand values. It recognises the six conditional branches, the PC-relative jump-and-link and the register-indirect jump-and-link. It reports whether control transfers, the transfer target and the return-link value. It also raises a flag when a transfer would land on an address that is not word aligned.

When the instruction is marked valid, the PC register moves on. It goes to the target if the transfer is taken. Otherwise it steps by one 4-byte instruction. A transfer to a misaligned target is not followed. The PC keeps its value, and one cycle later a single-cycle exception pulse appears together with the address of the offending transfer instruction. Writing the link value into the register file, trap vectoring and 16-bit instructions are handled elsewhere.

Top module: `bj_next_pc`

## Requirements
- R1: A synchronous active-high reset loads the PC with the parameter RESET_VEC and clears the exception pulse.
- R2: A branch (opcode 1100011) is taken per funct3 (bits 14:12): 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal, comparing rs1 against rs2.
- R3: The branch target is PC plus a sign-extended offset in 2-byte units, taken from instruction bits: 31 gives the sign and offset bit 12, 7 gives bit 11, 30:25 give bits 10:5, 11:8 give bits 4:1.
- R4: JAL (opcode 1101111) is always taken. Its target is the address of the JAL itself plus an offset taken from bits: 31 gives the sign and bit 20, 19:12 give bits 19:12, 20 gives bit 11, 30:21 give bits 10:1.
- R5: JALR (opcode 1100111) is always taken. Its target is rs1 plus the sign-extended 12-bit field in bits 31:20, with bit 0 of the sum cleared.
- R6: The link output equals PC+4.
- R7: The misaligned flag is high exactly when a taken transfer has a target whose two low bits are not both zero.
- R8: A branch that is not taken never raises the misaligned flag, whatever its encoded target.
- R9: On a valid instruction with no misaligned flag, the PC becomes the target when taken, else PC+4.
- R10: On a valid instruction with the misaligned flag, the PC holds. In the next cycle the exception pulse is high for one cycle, and the exception address output holds the transfer instruction's own PC.
- R11: Any other opcode, and a branch opcode with funct3 010 or 011, is not taken, raises no flag and advances the PC by 4.
- R12: While the valid input is low, the PC holds and no exception pulse follows, whatever the instruction inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | Instruction inputs are valid this cycle |
| instr_i | input | 32 | Instruction word at the current PC |
| rs1_i | input | 32 | First source operand value |
| rs2_i | input | 32 | Second source operand value |
| pc_o | output | 32 | Current PC register |
| taken_o | output | 1 | Control transfer taken |
| target_o | output | 32 | Transfer target address |
| link_o | output | 32 | Return link value (PC+4) |
| misalign_o | output | 1 | Taken transfer to a misaligned target |
| exc_valid_o | output | 1 | One-cycle misaligned-exception pulse |
| exc_pc_o | output | 32 | Address of the faulting transfer |

## Verification
The bench builds two copies side by side. Both use RESET_VEC = 32'h8000_0100, so the PC starts away from zero and PC-relative sums carry across high address bits. One copy sets SHARED_SUB = 1 and the other SHARED_SUB = 0, so the single-subtractor comparator and the separate-comparator variant see identical operands, including sign-boundary values such as all-ones against one. The same vectors reach the extreme negative branch and jump offsets, and the JALR bit-0 clearing with both odd and even sums.

// File: rtl/bj_pkg.sv
package bj_pkg;

    localparam int XLEN = 32;
    localparam int ILEN = 32;
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    localparam logic [2:0] CMP_EQ  = 3'b000;
    localparam logic [2:0] CMP_NE  = 3'b001;
    localparam logic [2:0] CMP_LT  = 3'b100;
    localparam logic [2:0] CMP_GE  = 3'b101;
    localparam logic [2:0] CMP_LTU = 3'b110;
    localparam logic [2:0] CMP_GEU = 3'b111;

    typedef enum logic [1:0] {
        XFER_NONE,
        XFER_BRANCH,
        XFER_JAL,
        XFER_JALR
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e      kind;
        logic [2:0]      cond;
        logic [XLEN-1:0] imm;
    } xfer_dec_t;

    // funct3 values 010 and 011 carry no branch condition
    function automatic logic cond_known(input logic [2:0] f3);
        return f3[2] | ~f3[1];
    endfunction

    function automatic logic [XLEN-1:0] imm_b(input logic [ILEN-1:0] w);
        return {{(XLEN-12){w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic logic [XLEN-1:0] imm_j(input logic [ILEN-1:0] w);
        return {{(XLEN-20){w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
    endfunction

    function automatic logic [XLEN-1:0] imm_i(input logic [ILEN-1:0] w);
        return {{(XLEN-11){w[31]}}, w[30:20]};
    endfunction

endpackage

// File: rtl/bj_decode.sv
module bj_decode
    import bj_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output xfer_dec_t       dec
);

    logic [6:0] opcode;
    logic [2:0] funct3;

    assign opcode = instr[6:0];
    assign funct3 = instr[14:12];

    always_comb begin
        dec.kind = XFER_NONE;
        dec.cond = funct3;
        dec.imm  = '0;
        case (opcode)
            OPC_BRANCH: begin
                if (cond_known(funct3)) begin
                    dec.kind = XFER_BRANCH;
                    dec.imm  = imm_b(instr);
                end
            end
            OPC_JAL: begin
                dec.kind = XFER_JAL;
                dec.imm  = imm_j(instr);
            end
            OPC_JALR: begin
                dec.kind = XFER_JALR;
                dec.imm  = imm_i(instr);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bj_compare.sv
module bj_compare
    import bj_pkg::*;
#(
    parameter bit SHARED_SUB = 1'b1
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [2:0]      cond,
    output logic            hit
);

    logic eq;
    logic lt_s;
    logic lt_u;

    assign eq = (a == b);

    generate
        if (SHARED_SUB) begin : g_shared
            logic [XLEN:0] diff;
            assign diff = {1'b0, a} - {1'b0, b};
            assign lt_u = diff[XLEN];
            // differing signs settle the signed order; equal signs reuse the borrow
            assign lt_s = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : diff[XLEN];
        end else begin : g_split
            assign lt_u = (a < b);
            assign lt_s = ($signed(a) < $signed(b));
        end
    endgenerate

    always_comb begin
        case (cond)
            CMP_EQ:  hit = eq;
            CMP_NE:  hit = ~eq;
            CMP_LT:  hit = lt_s;
            CMP_GE:  hit = ~lt_s;
            CMP_LTU: hit = lt_u;
            CMP_GEU: hit = ~lt_u;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bj_target.sv
module bj_target
    import bj_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    input  xfer_dec_t       dec,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] link
);

    logic            indirect;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] sum;

    assign indirect = (dec.kind == XFER_JALR);
    assign base     = indirect ? rs1 : pc;
    assign sum      = base + dec.imm;
    assign target   = {sum[XLEN-1:1], sum[0] & ~indirect};
    assign link     = pc + INSN_BYTES;

endmodule

// File: rtl/bj_next_pc.sv
module bj_next_pc
    import bj_pkg::*;
#(
    parameter logic [31:0] RESET_VEC  = 32'h0000_0000,
    parameter bit          SHARED_SUB = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs1_i,
    input  logic [31:0] rs2_i,
    output logic [31:0] pc_o,
    output logic        taken_o,
    output logic [31:0] target_o,
    output logic [31:0] link_o,
    output logic        misalign_o,
    output logic        exc_valid_o,
    output logic [31:0] exc_pc_o
);

    xfer_dec_t       dec;
    logic            cond_hit;
    logic            taken;
    logic            misalign;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] link;
    logic [XLEN-1:0] pc_q;
    logic            exc_q;
    logic [XLEN-1:0] exc_pc_q;

    bj_decode u_decode (
        .instr (instr_i),
        .dec   (dec)
    );

    bj_compare #(.SHARED_SUB(SHARED_SUB)) u_compare (
        .a    (rs1_i),
        .b    (rs2_i),
        .cond (dec.cond),
        .hit  (cond_hit)
    );

    bj_target u_target (
        .pc     (pc_q),
        .rs1    (rs1_i),
        .dec    (dec),
        .target (target),
        .link   (link)
    );

    always_comb begin
        case (dec.kind)
            XFER_BRANCH:         taken = cond_hit;
            XFER_JAL, XFER_JALR: taken = 1'b1;
            default:             taken = 1'b0;
        endcase
    end

    assign misalign = taken & (target[1:0] != 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_VEC;
            exc_q    <= 1'b0;
            exc_pc_q <= '0;
        end else begin
            exc_q <= instr_valid_i & misalign;
            if (instr_valid_i) begin
                if (misalign) begin
                    exc_pc_q <= pc_q;
                end else begin
                    pc_q <= taken ? target : link;
                end
            end
        end
    end

    assign pc_o        = pc_q;
    assign taken_o     = taken;
    assign target_o    = target;
    assign link_o      = link;
    assign misalign_o  = misalign;
    assign exc_valid_o = exc_q;
    assign exc_pc_o    = exc_pc_q;

endmodule

// File: rtl/bj_next_pc_chk.sv
module bj_next_pc_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid_i,
    input logic [31:0] pc_o,
    input logic        taken_o,
    input logic [31:0] target_o,
    input logic        misalign_o,
    input logic        exc_valid_o
);

    assert_pc_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);

    assert_no_exc_untaken_R8: assert property (@(posedge clk) disable iff (rst)
        !taken_o |-> !misalign_o);

    assert_seq_advance_R9: assert property (@(posedge clk) disable iff (rst)
        instr_valid_i && !taken_o |=> pc_o == $past(pc_o) + 32'd4);

    assert_take_target_R9: assert property (@(posedge clk) disable iff (rst)
        instr_valid_i && taken_o && !misalign_o |=> pc_o == $past(target_o));

    assert_exc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        instr_valid_i && misalign_o |=> exc_valid_o && $stable(pc_o));

    assert_exc_origin_R10: assert property (@(posedge clk) disable iff (rst)
        exc_valid_o |-> $past(instr_valid_i && misalign_o));

endmodule

bind bj_next_pc bj_next_pc_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_valid_i (instr_valid_i),
    .pc_o          (pc_o),
    .taken_o       (taken_o),
    .target_o      (target_o),
    .misalign_o    (misalign_o),
    .exc_valid_o   (exc_valid_o)
);

// File: tb/bj_next_pc_bench.sv
module bj_next_pc_bench;

    localparam logic [31:0] RV = 32'h8000_0100;
    localparam logic [1:0] K_BR = 2'd0, K_JAL = 2'd1, K_JALR = 2'd2, K_OTH = 2'd3;
    localparam int NV = 20;

    // {kind, funct3, expected taken, offset, rs1, rs2}
    localparam logic [101:0] TBL [NV] = '{
        {K_BR,   3'b000, 1'b1, 32'h0000_0010, 32'd5,         32'd5},
        {K_BR,   3'b000, 1'b0, 32'h0000_0010, 32'd5,         32'd6},
        {K_BR,   3'b001, 1'b1, 32'hFFFF_FFF8, 32'd1,         32'd2},
        {K_BR,   3'b100, 1'b1, 32'h0000_000C, 32'hFFFF_FFFF, 32'd1},
        {K_BR,   3'b110, 1'b0, 32'h0000_000C, 32'hFFFF_FFFF, 32'd1},
        {K_BR,   3'b110, 1'b1, 32'h0000_0008, 32'd1,         32'hFFFF_FFFF},
        {K_BR,   3'b101, 1'b1, 32'hFFFF_F000, 32'd1,         32'hFFFF_FFFF},
        {K_BR,   3'b111, 1'b0, 32'h0000_0014, 32'd1,         32'hFFFF_FFFF},
        {K_BR,   3'b111, 1'b1, 32'h0000_0004, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {K_BR,   3'b101, 1'b1, 32'h0000_0FFE, 32'd7,         32'd7},
        {K_BR,   3'b001, 1'b0, 32'h0000_0006, 32'd9,         32'd9},
        {K_JAL,  3'b000, 1'b1, 32'h0000_0800, 32'd0,         32'd0},
        {K_JAL,  3'b000, 1'b1, 32'hFFFF_FFFE, 32'd0,         32'd0},
        {K_JAL,  3'b000, 1'b1, 32'hFFF0_0000, 32'd0,         32'd0},
        {K_JALR, 3'b000, 1'b1, 32'h0000_0005, 32'h0000_3000, 32'd0},
        {K_JALR, 3'b000, 1'b1, 32'hFFFF_FFFF, 32'h0000_2000, 32'd0},
        {K_JALR, 3'b000, 1'b1, 32'h0000_07FF, 32'h0000_4001, 32'd0},
        {K_OTH,  3'b000, 1'b0, 32'h0000_07FF, 32'd0,         32'd0},
        {K_BR,   3'b010, 1'b0, 32'h0000_0008, 32'd3,         32'd3},
        {K_BR,   3'b011, 1'b0, 32'h0000_0008, 32'd3,         32'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1 = '0;
    logic [31:0] rs2 = '0;

    logic [31:0] pc     [2];
    logic        taken  [2];
    logic [31:0] target [2];
    logic [31:0] link   [2];
    logic        mis    [2];
    logic        excv   [2];
    logic [31:0] excpc  [2];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bj_next_pc #(.RESET_VEC(RV), .SHARED_SUB(1'b1)) u_bj_next_pc (
        .clk(clk), .rst(rst), .instr_valid_i(vld), .instr_i(instr),
        .rs1_i(rs1), .rs2_i(rs2), .pc_o(pc[0]), .taken_o(taken[0]),
        .target_o(target[0]), .link_o(link[0]), .misalign_o(mis[0]),
        .exc_valid_o(excv[0]), .exc_pc_o(excpc[0])
    );

    bj_next_pc #(.RESET_VEC(RV), .SHARED_SUB(1'b0)) u_bj_next_pc_split (
        .clk(clk), .rst(rst), .instr_valid_i(vld), .instr_i(instr),
        .rs1_i(rs1), .rs2_i(rs2), .pc_o(pc[1]), .taken_o(taken[1]),
        .target_o(target[1]), .link_o(link[1]), .misalign_o(mis[1]),
        .exc_valid_o(excv[1]), .exc_pc_o(excpc[1])
    );

    function automatic logic [31:0] enc(input logic [1:0] k, input logic [2:0] f3,
                                        input logic [31:0] o);
        case (k)
            K_BR:    return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'b1100011};
            K_JAL:   return {o[20], o[10:1], o[11], o[19:12], 5'd1, 7'b1101111};
            K_JALR:  return {o[11:0], 5'd1, 3'b000, 5'd1, 7'b1100111};
            default: return {o[11:0], 5'd3, f3, 5'd3, 7'b0010011};
        endcase
    endfunction

    task automatic chk(input string tag, input int d, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s dut%0d actual=%h expected=%h", tag, d, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_pc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk("R1 reset pc", d, pc[d], RV);
            chk("R1 reset exc", d, {31'd0, excv[d]}, 32'd0);
        end
        rst = 1'b0;
        exp_pc = RV;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [2:0]  f3;
            logic        etk;
            logic [31:0] off;
            logic [31:0] etgt;
            logic        emis;
            logic [31:0] enext;
            string       ttag;
            string       gtag;
            {k, f3, etk, off, rs1, rs2} = TBL[i];
            @(negedge clk);
            vld   = 1'b1;
            instr = enc(k, f3, off);
            etgt  = (k == K_JALR) ? ((rs1 + off) & 32'hFFFF_FFFE) : (exp_pc + off);
            emis  = etk && (etgt[1:0] != 2'b00);
            enext = emis ? exp_pc : (etk ? etgt : exp_pc + 32'd4);
            ttag  = (k == K_OTH || (k == K_BR && f3[2:1] == 2'b01)) ? "R11 taken" : "R2 taken";
            gtag  = (k == K_BR) ? "R3 target" : ((k == K_JAL) ? "R4 target" : "R5 target");
            #1;
            for (int d = 0; d < 2; d++) begin
                chk(ttag, d, {31'd0, taken[d]}, {31'd0, etk});
                if (etk) chk(gtag, d, target[d], etgt);
                chk("R6 link", d, link[d], exp_pc + 32'd4);
                chk(etk ? "R7 misalign" : "R8 misalign", d, {31'd0, mis[d]}, {31'd0, emis});
            end
            @(posedge clk);
            #1;
            for (int d = 0; d < 2; d++) begin
                chk(emis ? "R10 pc hold" : "R9 pc next", d, pc[d], enext);
                chk("R10 exc pulse", d, {31'd0, excv[d]}, {31'd0, emis});
                if (emis) chk("R10 exc pc", d, excpc[d], exp_pc);
            end
            exp_pc = enext;
        end

        // valid low with a misaligned jump on the inputs
        @(negedge clk);
        vld   = 1'b0;
        instr = enc(K_JAL, 3'b000, 32'h0000_0002);
        repeat (2) @(posedge clk);
        #1;
        for (int d = 0; d < 2; d++) begin
            chk("R12 pc hold", d, pc[d], exp_pc);
            chk("R12 no exc", d, {31'd0, excv[d]}, 32'd0);
        end

        // mid-run reset returns to the vector
        @(negedge clk);
        rst = 1'b1;
        vld = 1'b1;
        @(posedge clk);
        #1;
        for (int d = 0; d < 2; d++) begin
            chk("R1 rerun reset pc", d, pc[d], RV);
            chk("R1 rerun reset exc", d, {31'd0, excv[d]}, 32'd0);
        end
        @(negedge clk);
        rst = 1'b0;
        vld = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule